// File: doc/BRIEF.md
# Host/Engine Word Mailbox

This block moves 32-bit words between a host and an embedded engine through two independent ring buffers. The host side sees a small memory-mapped register port with four word addresses: a transmit window that pushes one word towards the engine, a receive window that pops one word sent by the engine, a host control/status word, and a read-only engine status word. The engine side has plain push and pop strobes with the head word always visible.

Each status word packs the ring depth and the ring's write and read pointers into one value. The pointers are 8-bit counters that wrap modulo 256, so software recovers the fill level as the 8-bit difference write minus read, and the free space as depth minus that fill. The host control word also holds an interrupt enable, a write-one-to-clear interrupt status, a doorbell bit that signals the engine, a host-ready flag and a reset request that flushes both rings when it is newly raised.

Top module: `mailbox_csr`

## Requirements
- R1: After reset, address 2 reads {DEPTH[7:0], 8'h00, 8'h00, 8'h00} and address 3 reads {DEPTH[7:0], 8'h00, 8'h00, 7'h0, engReady}. In both words bits [31:24] hold the depth, [23:16] the write pointer and [15:8] the read pointer of the ring (address 2: host-to-engine ring, address 3: engine-to-host ring).
- R2: Each host write to address 0 pushes one word into the host-to-engine ring and advances its write pointer by one; the engine pops words in the order written, each pop advancing the read pointer by one.
- R3: A push into a ring holding DEPTH words is dropped and leaves the pointers unchanged; a dropped host write sets the sticky overflow bit 5 of address 2, which is cleared by writing 1 to it. The fill level never exceeds DEPTH.
- R4: Each host read of address 1 returns and removes the oldest engine word; a read with the ring empty returns 0 and leaves the read pointer unchanged.
- R5: Pointers wrap modulo 256, and write minus read (8-bit) stays the true fill level across the wrap.
- R6: A pulse on engRing sets interrupt status bit 1 of address 2; hostIrq is high when bits 1 and 0 (enable) are both set; writing 1 to bit 1 clears it, writing 0 leaves it set, so writing back a read value clears it.
- R7: Writing address 2 with bit 2 set drives engDoorbell high for exactly one cycle; bit 2 always reads 0.
- R8: Writing bit 3 (reset) of address 2 as 1 while it is 0 empties both rings (all pointers 0), clears host-ready bit 4 and both overflow flags; engHostReset follows bit 3 and engHostReady follows bit 4.
- R9: Writing bit 3 as 1 while it is already 1 does not flush; clearing it and setting it again flushes.
- R10: A single write with bit 3 = 0 and bit 2 = 1 releases reset and rings the doorbell in the same step.
- R11: Address 3 bit 0 reflects engReady; an engine push into a full ring is dropped, engTxFull is high, and bit 1 of address 3 is set until the next reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 2 | Host register word address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid while hostRd is high |
| hostIrq | output | 1 | Host interrupt request |
| engPush | input | 1 | Engine push strobe into engine-to-host ring |
| engPushData | input | 32 | Engine push word |
| engTxFull | output | 1 | Engine-to-host ring is full |
| engPop | input | 1 | Engine pop strobe from host-to-engine ring |
| engPopData | output | 32 | Oldest host word, 0 when empty |
| engRxValid | output | 1 | Host-to-engine ring holds a word |
| engReady | input | 1 | Engine ready flag |
| engRing | input | 1 | Engine interrupt request pulse |
| engDoorbell | output | 1 | One-cycle doorbell pulse to the engine |
| engHostReady | output | 1 | Host-ready flag |
| engHostReset | output | 1 | Host reset request |

## Verification
The hardest state to reach is the pointer wrap: the 8-bit pointers only pass 255 after hundreds of transfers, so the bench streams 250 push/pop pairs through the host-to-engine ring after earlier tests have already moved it past zero, then checks that the pointer difference still reads as the true fill level. The second awkward case is a reset request repeated while reset is held; the bench deposits words during the held reset so that a wrongful flush would show as a zeroed write pointer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int PTR_W  = 8;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ADDR_TXWIN = 2'd0,
    ADDR_RXWIN = 2'd1,
    ADDR_HCTL  = 2'd2,
    ADDR_ESTAT = 2'd3
  } mbxAddr_e;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic flush;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
  parameter int DEPTH = 8,
  parameter int PW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] popData,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] fill;
  logic          doPush, doPop;

  assign fill   = wptr - rptr;
  assign full   = (fill == DEPTH_P);
  assign empty  = (fill == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign popData = empty ? '0 : mem[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (doPush) wptr <= wptr + 1'b1;
      if (doPop)  rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wptr[AW-1:0]] <= pushData;
  end

  // R3: a push against a full ring leaves the write pointer alone
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !flush) |=> (wptr == $past(wptr)));
  // R3: fill level bounded by the depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wptr - rptr) <= DEPTH_P);
  // R4: a pop from an empty ring leaves the read pointer alone
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !flush) |=> (rptr == $past(rptr)));
  // R2: an accepted push advances the write pointer by one
  p_wptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (push && !full && !flush) |=> (wptr == $past(wptr) + 1'b1));
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strobe,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic              engPush,
  input  logic [WORD_W-1:0] engPushData,
  input  logic              engPop,
  output logic [WORD_W-1:0] txHead,
  output logic [WORD_W-1:0] rxHead,
  output logic [PTR_W-1:0]  txWptr,
  output logic [PTR_W-1:0]  txRptr,
  output logic [PTR_W-1:0]  rxWptr,
  output logic [PTR_W-1:0]  rxRptr,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty
);
  // host-to-engine ring
  mbx_ring #(.DEPTH(DEPTH), .PW(PTR_W), .DW(WORD_W)) txRing_i (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(strobe.txPush), .pushData(hostWdata),
    .pop(engPop), .popData(txHead),
    .wptr(txWptr), .rptr(txRptr), .full(txFull), .empty(txEmpty)
  );

  // engine-to-host ring
  mbx_ring #(.DEPTH(DEPTH), .PW(PTR_W), .DW(WORD_W)) rxRing_i (
    .clk(clk), .rstN(rstN), .flush(strobe.flush),
    .push(engPush), .pushData(engPushData),
    .pop(strobe.rxPop), .popData(rxHead),
    .wptr(rxWptr), .rptr(rxRptr), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [5:0]        ctlWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              hostIrq,
  input  logic [WORD_W-1:0] rxHead,
  input  logic [PTR_W-1:0]  txWptr,
  input  logic [PTR_W-1:0]  txRptr,
  input  logic [PTR_W-1:0]  rxWptr,
  input  logic [PTR_W-1:0]  rxRptr,
  input  logic              txFull,
  input  logic              rxFull,
  input  logic              engPush,
  input  logic              engReady,
  input  logic              engRing,
  output mbxStrobe_t        strobe,
  output logic              engDoorbell,
  output logic              engHostReady,
  output logic              engHostReset
);
  localparam logic [7:0] DEPTH_F = 8'(DEPTH);

  logic intEn, intSts, rstReq, hostRdy, txOvf, rxOvf;
  logic ctlWr, rstRise;

  assign ctlWr   = hostWr && (hostAddr == ADDR_HCTL);
  assign rstRise = ctlWr && ctlWdata[3] && !rstReq;

  always_comb begin
    strobe.txPush = hostWr && (hostAddr == ADDR_TXWIN);
    strobe.rxPop  = hostRd && (hostAddr == ADDR_RXWIN);
    strobe.flush  = rstRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn       <= 1'b0;
      intSts      <= 1'b0;
      rstReq      <= 1'b0;
      hostRdy     <= 1'b0;
      txOvf       <= 1'b0;
      rxOvf       <= 1'b0;
      engDoorbell <= 1'b0;
    end else begin
      engDoorbell <= ctlWr && ctlWdata[2];
      if (ctlWr) begin
        intEn   <= ctlWdata[0];
        rstReq  <= ctlWdata[3];
        hostRdy <= rstRise ? 1'b0 : ctlWdata[4];
      end
      // interrupt status: set wins over write-one-to-clear
      if (engRing)                        intSts <= 1'b1;
      else if (ctlWr && ctlWdata[1])      intSts <= 1'b0;
      // host overflow: sticky, write-one-to-clear, flushed by reset request
      if (rstRise)                        txOvf <= 1'b0;
      else if (strobe.txPush && txFull)   txOvf <= 1'b1;
      else if (ctlWr && ctlWdata[5])      txOvf <= 1'b0;
      // engine overflow: sticky until the next reset request
      if (rstRise)                        rxOvf <= 1'b0;
      else if (engPush && rxFull)         rxOvf <= 1'b1;
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostRd) begin
      unique case (mbxAddr_e'(hostAddr))
        ADDR_TXWIN: hostRdata = '0;
        ADDR_RXWIN: hostRdata = rxHead;
        ADDR_HCTL:  hostRdata = {DEPTH_F, txWptr, txRptr,
                                 2'b00, txOvf, hostRdy, rstReq, 1'b0, intSts, intEn};
        ADDR_ESTAT: hostRdata = {DEPTH_F, rxWptr, rxRptr, 6'b0, rxOvf, engReady};
        default:    hostRdata = '0;
      endcase
    end
  end

  assign hostIrq      = intSts && intEn;
  assign engHostReady = hostRdy;
  assign engHostReset = rstReq;

  // R6: an engine ring pulse always leaves status pending
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    engRing |=> intSts);
  // R7: doorbell only follows a control write carrying the generate bit
  p_doorbell_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engDoorbell) |-> $past(ctlWr && ctlWdata[2]));
  // R8: a fresh reset request drops host ready
  p_rst_clears_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    rstRise |=> !engHostReady);
  // R9: a repeated reset request keeps reset asserted without a flush
  p_rst_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && ctlWdata[3] && rstReq) |-> !strobe.flush);
endmodule

// File: rtl/mailbox_csr.sv
module mailbox_csr
  import mbx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  hostAddr,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostIrq,
  input  logic        engPush,
  input  logic [31:0] engPushData,
  output logic        engTxFull,
  input  logic        engPop,
  output logic [31:0] engPopData,
  output logic        engRxValid,
  input  logic        engReady,
  input  logic        engRing,
  output logic        engDoorbell,
  output logic        engHostReady,
  output logic        engHostReset
);
  mbxStrobe_t        strobe;
  logic [WORD_W-1:0] rxHead;
  logic [PTR_W-1:0]  txWptr, txRptr, rxWptr, rxRptr;
  logic              txFull, txEmpty, rxFull, rxEmpty;

  mbx_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .ctlWdata(hostWdata[5:0]), .hostRdata(hostRdata), .hostIrq(hostIrq),
    .rxHead(rxHead), .txWptr(txWptr), .txRptr(txRptr),
    .rxWptr(rxWptr), .rxRptr(rxRptr), .txFull(txFull), .rxFull(rxFull),
    .engPush(engPush), .engReady(engReady), .engRing(engRing),
    .strobe(strobe), .engDoorbell(engDoorbell),
    .engHostReady(engHostReady), .engHostReset(engHostReset)
  );

  mbx_datapath #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(hostWdata),
    .engPush(engPush), .engPushData(engPushData), .engPop(engPop),
    .txHead(engPopData), .rxHead(rxHead),
    .txWptr(txWptr), .txRptr(txRptr), .rxWptr(rxWptr), .rxRptr(rxRptr),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );

  assign engTxFull  = rxFull;
  assign engRxValid = !txEmpty;
endmodule

// File: tb/mailbox_csr_tb_top.sv
module mailbox_csr_tb_top;
  localparam int DEPTH = 8;
  localparam logic [7:0] D8 = 8'(DEPTH);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostIrq;
  logic        engPush = 1'b0;
  logic [31:0] engPushData = '0;
  logic        engTxFull;
  logic        engPop = 1'b0;
  logic [31:0] engPopData;
  logic        engRxValid;
  logic        engReady = 1'b0, engRing = 1'b0;
  logic        engDoorbell, engHostReady, engHostReset;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mailbox_csr #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIrq(hostIrq),
    .engPush(engPush), .engPushData(engPushData), .engTxFull(engTxFull),
    .engPop(engPop), .engPopData(engPopData), .engRxValid(engRxValid),
    .engReady(engReady), .engRing(engRing), .engDoorbell(engDoorbell),
    .engHostReady(engHostReady), .engHostReset(engHostReset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic engPushWord(input logic [31:0] d);
    @(negedge clk); engPushData = d; engPush = 1'b1;
    @(negedge clk); engPush = 1'b0;
  endtask

  task automatic engPopWord(output logic [31:0] d);
    @(negedge clk); d = engPopData; engPop = 1'b1;
    @(negedge clk); engPop = 1'b0;
  endtask

  task automatic testResetState();
    logic [31:0] v;
    hostRead(2'd2, v); chk("R1 host status after reset", v, {D8, 24'h0});
    hostRead(2'd3, v); chk("R1 engine status after reset", v, {D8, 24'h0});
    chk("R1 irq low after reset", {31'b0, hostIrq}, 32'h0);
    chk("R1 no engine word after reset", {31'b0, engRxValid}, 32'h0);
  endtask

  task automatic testPushPop();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) hostWrite(2'd0, 32'h1000 + i);
    hostRead(2'd2, v); chk("R1 R2 tx write pointer field", v[31:8], {D8, 8'd3, 8'd0});
    for (int i = 0; i < 3; i++) begin
      engPopWord(v); chk("R2 engine pop order", v, 32'h1000 + i);
    end
    hostRead(2'd2, v); chk("R2 tx read pointer field", v[15:8], 8'd3);
  endtask

  task automatic testFull();
    logic [31:0] v;
    logic [7:0] fill;
    for (int i = 0; i < DEPTH; i++) hostWrite(2'd0, 32'h100 + i);
    hostWrite(2'd0, 32'hDEAD);
    hostRead(2'd2, v);
    chk("R3 drop keeps write pointer", v[23:16], 8'(3 + DEPTH));
    chk("R3 overflow flag set", {31'b0, v[5]}, 32'h1);
    fill = v[23:16] - v[15:8];
    chk("R3 free slots zero", 32'(D8 - fill), 32'h0);
    hostWrite(2'd2, 32'h20);
    hostRead(2'd2, v); chk("R3 overflow cleared by W1C", {31'b0, v[5]}, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      engPopWord(v); chk("R3 stored words survive drop", v, 32'h100 + i);
    end
    chk("R3 ring empty after drain", {31'b0, engRxValid}, 32'h0);
  endtask

  task automatic testRxRead();
    logic [31:0] v;
    engPushWord(32'hAAAA0001);
    engPushWord(32'hAAAA0002);
    hostRead(2'd1, v); chk("R4 first rx word", v, 32'hAAAA0001);
    hostRead(2'd1, v); chk("R4 second rx word", v, 32'hAAAA0002);
    hostRead(2'd1, v); chk("R4 empty read returns zero", v, 32'h0);
    hostRead(2'd3, v); chk("R4 rx read pointer unchanged on empty", v[23:8], {8'd2, 8'd2});
  endtask

  task automatic testWrap();
    logic [31:0] v;
    int bad = 0;
    logic [7:0] expPtr;
    for (int i = 0; i < 250; i++) begin
      hostWrite(2'd0, 32'h5A000000 ^ i);
      engPopWord(v);
      if (v !== (32'h5A000000 ^ i)) bad++;
    end
    chk("R5 data across pointer wrap", 32'(bad), 32'h0);
    expPtr = 8'(3 + DEPTH + 250);
    hostRead(2'd2, v); chk("R5 wrapped pointers", v[23:8], {expPtr, expPtr});
    hostWrite(2'd0, 32'h77);
    hostRead(2'd2, v); chk("R5 fill after wrap", 32'(8'(v[23:16] - v[15:8])), 32'h1);
    engPopWord(v);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    @(negedge clk); engRing = 1'b1;
    @(negedge clk); engRing = 1'b0;
    hostRead(2'd2, v); chk("R6 status set by ring", {31'b0, v[1]}, 32'h1);
    chk("R6 irq masked when disabled", {31'b0, hostIrq}, 32'h0);
    hostWrite(2'd2, 32'h01);
    chk("R6 irq with enable", {31'b0, hostIrq}, 32'h1);
    hostRead(2'd2, v); v[1] = 1'b1;
    hostWrite(2'd2, 32'h01);
    chk("R6 writing zero keeps status", {31'b0, hostIrq}, 32'h1);
    hostWrite(2'd2, v);
    chk("R6 write back clears status", {31'b0, hostIrq}, 32'h0);
  endtask

  task automatic testDoorbell();
    logic [31:0] v;
    hostWrite(2'd2, 32'h04);
    chk("R7 doorbell high after write", {31'b0, engDoorbell}, 32'h1);
    @(negedge clk);
    chk("R7 doorbell one cycle", {31'b0, engDoorbell}, 32'h0);
    hostRead(2'd2, v); chk("R7 generate reads zero", {31'b0, v[2]}, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    hostWrite(2'd0, 32'h99);
    engPushWord(32'h88);
    hostWrite(2'd2, 32'h10);
    chk("R8 host ready output", {31'b0, engHostReady}, 32'h1);
    hostWrite(2'd2, 32'h18);
    chk("R8 reset output", {31'b0, engHostReset}, 32'h1);
    chk("R8 ready cleared", {31'b0, engHostReady}, 32'h0);
    hostRead(2'd2, v); chk("R8 tx pointers flushed", v[23:8], 16'h0);
    hostRead(2'd3, v); chk("R8 rx pointers flushed", v[23:8], 16'h0);
    chk("R8 engine side empty", {31'b0, engRxValid}, 32'h0);
  endtask

  task automatic testResetRepeat();
    logic [31:0] v;
    hostWrite(2'd0, 32'h1); hostWrite(2'd0, 32'h2);
    hostWrite(2'd2, 32'h08);
    hostRead(2'd2, v); chk("R9 repeat set does not flush", v[23:16], 8'd2);
    hostWrite(2'd2, 32'h04);
    chk("R10 release rings doorbell", {31'b0, engDoorbell}, 32'h1);
    chk("R10 reset released", {31'b0, engHostReset}, 32'h0);
    hostWrite(2'd2, 32'h08);
    hostRead(2'd2, v); chk("R9 clear then set flushes", v[23:16], 8'd0);
  endtask

  task automatic testEngine();
    logic [31:0] v;
    engReady = 1'b1;
    hostRead(2'd3, v); chk("R11 engine ready bit", {31'b0, v[0]}, 32'h1);
    for (int i = 0; i <= DEPTH; i++) engPushWord(32'hE0 + i);
    chk("R11 engine full flag", {31'b0, engTxFull}, 32'h1);
    hostRead(2'd3, v);
    chk("R11 engine overflow bit", {31'b0, v[1]}, 32'h1);
    chk("R11 engine write pointer at depth", 32'(v[23:16]), 32'(DEPTH));
    hostWrite(2'd2, 32'h00); hostWrite(2'd2, 32'h08);
    hostRead(2'd3, v); chk("R11 overflow cleared by reset request", {31'b0, v[1]}, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testResetState();
    testPushPop();
    testFull();
    testRxRead();
    testWrap();
    testIrq();
    testDoorbell();
    testReset();
    testResetRepeat();
    testEngine();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule